// File: doc/BRIEF.md
# Software Write-Protect Command Unit

This unit sits beside a two-wire serial EEPROM slave. It watches the same byte stream the slave receives. Bytes whose upper address nibble is the protect-instruction device code are taken as protect instructions, and the slave's memory decoding is left out of them.

The unit keeps two nonvolatile protect flags:
- a reversible flag, which can be set and cleared;
- a permanent flag, which can only ever be set.

From these flags it tells the slave two things. First, whether the lower half of the memory may be written. Second, whether to acknowledge each byte of a protect instruction.

A write-form instruction looks like a byte write: an address byte, a don't-care word byte and a don't-care data byte, then a stop. It takes effect only on that stop. A read-form instruction reports a flag's state through the acknowledge of its address byte alone.

The reversible instructions are accepted only while an elevated-level indication on the lowest strap input is present. The permanent instruction is selected by the device's own strap value. Once the permanent flag is set, the unit never acknowledges a protect instruction again.

The flags are modelled as registers that only a separate storage-initialisation reset loads, each from a preset parameter. The interface reset leaves them untouched.

Top module: `swp_cmd_unit`

## Requirements
- R1: After storage initialisation and interface reset with default presets, both flags are clear, `lower_prot` is 0, `ack_en` is 0 and `prot_sel` is 0.
- R2: An address byte whose bits [7:4] are not 0110 is not claimed. `prot_sel` and `ack_en` stay 0 and no flag changes.
- R3: A write-form address byte (bits [7:4] = 0110, bit 0 = 0) is decoded from slave bits [3:1]:
  - 001 with `hv_a0` high is set-reversible;
  - 011 with `hv_a0` high is clear-reversible;
  - a value equal to `strap` is set-permanent.
  
  The byte is acknowledged only when it is one of these, `wp` is low and the permanent flag is clear. After an acknowledged write-form address, the word byte and the data byte are both acknowledged. Every other byte of a protect instruction is not acknowledged.
- R4: A stop that follows the acknowledged data byte applies the decoded instruction:
  - set-reversible sets the reversible flag;
  - clear-reversible clears the reversible flag only;
  - set-permanent sets the permanent flag.
- R5: No flag changes if the instruction ends early or runs long. This covers a stop before the data byte, a new start before the stop, and any byte after the data byte. A byte after the data byte is not acknowledged.
- R6: With `wp` high at the address byte, no write-form instruction is acknowledged. With `wp` high at the stop, no flag changes.
- R7: A read-form address byte (bit 0 = 1) is acknowledged only when it decodes as in R3 and its flag is clear. Slave 001 or 011 reports the reversible flag; the strap value reports the permanent flag. The bytes after it are not acknowledged, and no flag changes.
- R8: `lower_prot` is the OR of the two flags. `wr_ok` is 0 whenever `wp` is high, 0 when `lower_prot` is high and `mem_addr` is below 80h, and 1 otherwise.
- R9: Once set, the permanent flag stays set. Neither `wp`, a clear-reversible instruction nor `rst_n` clears it. No further 0110 address byte is acknowledged.
- R10: `prot_sel` goes high after any address byte with bits [7:4] = 0110, whether acknowledged or not. It stays high until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low interface reset |
| nv_init_n | input | 1 | Asynchronous active-low storage initialisation, loads the flag presets |
| strap | input | 3 | Strapped slave address bits |
| hv_a0 | input | 1 | Elevated-level indication on the lowest strap input |
| wp | input | 1 | Hardware write-protect level |
| bus_start | input | 1 | One-cycle strobe: start condition seen |
| byte_strb | input | 1 | One-cycle strobe: `rx_byte` holds a completed byte |
| rx_byte | input | 8 | Received byte |
| stop_strb | input | 1 | One-cycle strobe: stop condition seen |
| mem_addr | input | AW | Memory address the slave wants to write |
| ack_en | output | 1 | Acknowledge the byte last strobed |
| prot_sel | output | 1 | Current transaction is a protect instruction |
| lower_prot | output | 1 | Lower memory half is software protected |
| wr_ok | output | 1 | Write to `mem_addr` is allowed |

## Verification
The main sweep tries every slave-bit pattern in both directions, under both `hv_a0` levels and both `wp` levels. A bench model tracks the flags through it. This separates:
- the reversible codes from the strap code;
- the elevated-level gating from the write-protect refusal;
- read-form status reporting from write-form updates.

Truncated, restarted and overlong instructions, and `wp` rising between address and stop, show that only a well-formed stop commits. Every memory address is then checked against both `wp` levels in three flag states: no protection, reversible only, and permanent. An interface reset pulse and a refused clear-reversible after the permanent set confirm that both flags survive.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_SET_REV  = 2'd1,
    OP_CLR_REV  = 2'd2,
    OP_SET_PERM = 2'd3
  } swp_op_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_WORD = 3'd2,
    PH_DATA = 3'd3,
    PH_ARM  = 3'd4
  } swp_ph_e;

  typedef struct packed {
    logic    claim;
    logic    ack;
    logic    wr_go;
    swp_op_e op;
  } swp_dec_t;

endpackage

// File: rtl/swp_decode.sv
module swp_decode
  import swp_pkg::*;
#(
  parameter logic [3:0] CODE    = 4'b0110,
  parameter logic [2:0] REV_SET = 3'b001,
  parameter logic [2:0] REV_CLR = 3'b011
) (
  input  logic [7:0] addr_byte,
  input  logic [2:0] strap,
  input  logic       hv,
  input  logic       wp,
  input  logic       rev,
  input  logic       perm,
  output swp_dec_t   dec
);

  logic       code_hit;
  logic [2:0] slv;
  logic       rd;
  logic       status_clear;
  swp_op_e    op;

  always_comb begin
    code_hit = (addr_byte[7:4] == CODE);
    slv      = addr_byte[3:1];
    rd       = addr_byte[0];

    // Reversible codes need the elevated level; otherwise the strap value selects the permanent set.
    if (hv && (slv == REV_SET))      op = OP_SET_REV;
    else if (hv && (slv == REV_CLR)) op = OP_CLR_REV;
    else if (slv == strap)           op = OP_SET_PERM;
    else                             op = OP_NONE;

    status_clear = (op == OP_SET_PERM) ? !perm : !rev;

    dec.claim = code_hit;
    dec.ack   = code_hit && !perm && (op != OP_NONE) && (rd ? status_clear : !wp);
    dec.wr_go = dec.ack && !rd;
    dec.op    = op;
  end

endmodule

// File: rtl/swp_seq.sv
module swp_seq
  import swp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bus_start,
  input  logic     byte_strb,
  input  logic     stop_strb,
  input  logic     wp,
  input  swp_dec_t dec,
  output logic     ack_en,
  output logic     prot_sel,
  output logic     commit,
  output swp_op_e  commit_op
);

  swp_ph_e ph_q, ph_d;
  logic    ack_q, ack_d;
  logic    sel_q, sel_d;
  swp_op_e op_q, op_d;

  always_comb begin
    ph_d  = ph_q;
    ack_d = ack_q;
    sel_d = sel_q;
    op_d  = op_q;
    if (bus_start) begin
      ph_d  = PH_ADDR;
      ack_d = 1'b0;
      sel_d = 1'b0;
      op_d  = OP_NONE;
    end else if (stop_strb) begin
      ph_d  = PH_IDLE;
      ack_d = 1'b0;
      sel_d = 1'b0;
      op_d  = OP_NONE;
    end else if (byte_strb) begin
      case (ph_q)
        PH_ADDR: begin
          ack_d = dec.ack;
          sel_d = dec.claim;
          ph_d  = dec.wr_go ? PH_WORD : PH_IDLE;
          op_d  = dec.wr_go ? dec.op : OP_NONE;
        end
        PH_WORD: begin
          ack_d = 1'b1;
          ph_d  = PH_DATA;
        end
        PH_DATA: begin
          ack_d = 1'b1;
          ph_d  = PH_ARM;
        end
        default: begin
          ack_d = 1'b0;
          ph_d  = PH_IDLE;
          op_d  = OP_NONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      ack_q <= 1'b0;
      sel_q <= 1'b0;
      op_q  <= OP_NONE;
    end else begin
      ph_q  <= ph_d;
      ack_q <= ack_d;
      sel_q <= sel_d;
      op_q  <= op_d;
    end
  end

  assign commit    = stop_strb && !bus_start && (ph_q == PH_ARM) && !wp;
  assign commit_op = op_q;
  assign ack_en    = ack_q;
  assign prot_sel  = sel_q;

  // R3
  ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_en) |-> $past(byte_strb));

  // R5
  no_early_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_ARM) |-> !commit);

endmodule

// File: rtl/swp_flags.sv
module swp_flags
  import swp_pkg::*;
#(
  parameter int   AW          = 8,
  parameter logic REV_PRESET  = 1'b0,
  parameter logic PERM_PRESET = 1'b0
) (
  input  logic          clk,
  input  logic          nv_init_n,
  input  logic          commit,
  input  swp_op_e       op,
  input  logic          wp,
  input  logic [AW-1:0] mem_addr,
  output logic          rev,
  output logic          perm,
  output logic          lower_prot,
  output logic          wr_ok
);

  localparam int TOP = AW - 1;

  logic rev_q, rev_d, perm_q, perm_d;

  always_comb begin
    rev_d  = rev_q;
    perm_d = perm_q;
    if (commit) begin
      case (op)
        OP_SET_REV:  rev_d  = 1'b1;
        OP_CLR_REV:  rev_d  = 1'b0;
        OP_SET_PERM: perm_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge nv_init_n) begin
    if (!nv_init_n) begin
      rev_q  <= REV_PRESET;
      perm_q <= PERM_PRESET;
    end else if (commit) begin
      rev_q  <= rev_d;
      perm_q <= perm_d;
    end
  end

  assign rev        = rev_q;
  assign perm       = perm_q;
  assign lower_prot = rev_q | perm_q;
  assign wr_ok      = !wp && !(lower_prot && !mem_addr[TOP]);

  // R9
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!nv_init_n)
    perm_q |=> perm_q);

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!nv_init_n)
    !commit |=> ($stable(rev_q) && $stable(perm_q)));

endmodule

// File: rtl/swp_cmd_unit.sv
module swp_cmd_unit
  import swp_pkg::*;
#(
  parameter int         AW          = 8,
  parameter logic [3:0] PROT_CODE   = 4'b0110,
  parameter logic       REV_PRESET  = 1'b0,
  parameter logic       PERM_PRESET = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_init_n,
  input  logic [2:0]    strap,
  input  logic          hv_a0,
  input  logic          wp,
  input  logic          bus_start,
  input  logic          byte_strb,
  input  logic [7:0]    rx_byte,
  input  logic          stop_strb,
  input  logic [AW-1:0] mem_addr,
  output logic          ack_en,
  output logic          prot_sel,
  output logic          lower_prot,
  output logic          wr_ok
);

  swp_dec_t dec;
  logic     rev, perm, commit;
  swp_op_e  commit_op;

  swp_decode #(.CODE(PROT_CODE)) u_dec (
    .addr_byte (rx_byte),
    .strap     (strap),
    .hv        (hv_a0),
    .wp        (wp),
    .rev       (rev),
    .perm      (perm),
    .dec       (dec)
  );

  swp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .byte_strb (byte_strb),
    .stop_strb (stop_strb),
    .wp        (wp),
    .dec       (dec),
    .ack_en    (ack_en),
    .prot_sel  (prot_sel),
    .commit    (commit),
    .commit_op (commit_op)
  );

  swp_flags #(
    .AW          (AW),
    .REV_PRESET  (REV_PRESET),
    .PERM_PRESET (PERM_PRESET)
  ) u_flags (
    .clk        (clk),
    .nv_init_n  (nv_init_n),
    .commit     (commit),
    .op         (commit_op),
    .wp         (wp),
    .mem_addr   (mem_addr),
    .rev        (rev),
    .perm       (perm),
    .lower_prot (lower_prot),
    .wr_ok      (wr_ok)
  );

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    wp |-> !wr_ok);

  // R8
  low_block_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    (lower_prot && !mem_addr[AW-1]) |-> !wr_ok);

  // R9
  perm_noack_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    (perm && byte_strb && !bus_start && !stop_strb && (rx_byte[7:4] == PROT_CODE)) |=> !ack_en);

endmodule

// File: tb/swp_cmd_unit_bench.sv
module swp_cmd_unit_bench;

  localparam logic [2:0] STRAP = 3'b101;

  logic       clk = 1'b0;
  logic       rst_n, nv_init_n, hv_a0, wp;
  logic       bus_start, byte_strb, stop_strb;
  logic [7:0] rx_byte, mem_addr;
  logic       ack_en, prot_sel, lower_prot, wr_ok;

  int  n_chk = 0;
  int  n_fail = 0;
  logic rev_m = 1'b0;
  logic perm_m = 1'b0;

  always #5 clk = ~clk;

  swp_cmd_unit u_swp_cmd_unit (
    .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n), .strap(STRAP),
    .hv_a0(hv_a0), .wp(wp), .bus_start(bus_start), .byte_strb(byte_strb),
    .rx_byte(rx_byte), .stop_strb(stop_strb), .mem_addr(mem_addr),
    .ack_en(ack_en), .prot_sel(prot_sel), .lower_prot(lower_prot), .wr_ok(wr_ok)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bstart();
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic bstop();
    stop_strb = 1'b1; @(negedge clk); stop_strb = 1'b0;
  endtask

  task automatic bbyte(input logic [7:0] b);
    rx_byte = b; byte_strb = 1'b1; @(negedge clk); byte_strb = 1'b0;
  endtask

  function automatic int model_op(input logic [7:0] b, input logic hvv);
    if (hvv && b[3:1] == 3'b001) return 1;
    if (hvv && b[3:1] == 3'b011) return 2;
    if (b[3:1] == STRAP) return 3;
    return 0;
  endfunction

  function automatic logic exp_ack(input logic [7:0] b, input logic hvv, input logic wpv);
    int op;
    op = model_op(b, hvv);
    if (b[7:4] != 4'b0110 || perm_m || op == 0) return 1'b0;
    if (!b[0]) return !wpv;
    return (op == 3) ? !perm_m : !rev_m;
  endfunction

  task automatic apply_op(input int op);
    if (op == 1) rev_m = 1'b1;
    else if (op == 2) rev_m = 1'b0;
    else if (op == 3) perm_m = 1'b1;
  endtask

  task automatic run_cmd(input logic [7:0] b, input logic hvv, input logic wpv);
    logic e;
    hv_a0 = hvv; wp = wpv;
    bstart();
    bbyte(b);
    e = exp_ack(b, hvv, wpv);
    chk(ack_en == e, b[0] ? "R7 address ack" : "R3 R6 address ack", ack_en, e);
    chk(prot_sel == (b[7:4] == 4'b0110), "R10 prot_sel", prot_sel, b[7:4] == 4'b0110);
    if (e && !b[0]) begin
      bbyte(8'h5A); chk(ack_en == 1'b1, "R3 word ack", ack_en, 1);
      bbyte(8'hC3); chk(ack_en == 1'b1, "R3 data ack", ack_en, 1);
      bstop();
      apply_op(model_op(b, hvv));
    end else begin
      bbyte(8'hFF);
      chk(ack_en == 1'b0, "R7 R3 following byte not acked", ack_en, 0);
      bstop();
    end
    chk(lower_prot == (rev_m | perm_m), "R4 R7 lower_prot", lower_prot, rev_m | perm_m);
    chk(prot_sel == 1'b0, "R10 prot_sel after stop", prot_sel, 0);
    wp = 1'b0;
  endtask

  task automatic sweep_wr();
    for (int a = 0; a < 256; a++) begin
      for (int w = 0; w < 2; w++) begin
        logic e;
        mem_addr = a[7:0]; wp = w[0];
        #1;
        e = !w[0] && !((rev_m | perm_m) && a < 128);
        chk(wr_ok == e, "R8 wr_ok", wr_ok, e);
      end
    end
    wp = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_rst();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog R1..R10 run: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nv_init_n = 1'b0; hv_a0 = 1'b0; wp = 1'b0;
    bus_start = 1'b0; byte_strb = 1'b0; stop_strb = 1'b0;
    rx_byte = 8'h00; mem_addr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; nv_init_n = 1'b1;
    @(negedge clk);

    // R1
    chk(lower_prot == 1'b0, "R1 lower_prot", lower_prot, 0);
    chk(ack_en == 1'b0, "R1 ack_en", ack_en, 0);
    chk(prot_sel == 1'b0, "R1 prot_sel", prot_sel, 0);

    // R2: memory device code and other codes are not claimed
    hv_a0 = 1'b1;
    bstart(); bbyte({4'b1010, STRAP, 1'b0});
    chk(ack_en == 1'b0, "R2 memory code ack", ack_en, 0);
    chk(prot_sel == 1'b0, "R2 memory code prot_sel", prot_sel, 0);
    bbyte(8'h00); bbyte(8'h00); bstop();
    bstart(); bbyte(8'h72); bbyte(8'h00); bbyte(8'h00); bstop();
    chk(lower_prot == 1'b0, "R2 no flag change", lower_prot, 0);

    // R3 R4 R6 R7 R10: sweep of protect codes
    for (int w = 0; w < 2; w++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < 8; s++)
          for (int r = 0; r < 2; r++) begin
            if (!(s[2:0] == STRAP && r == 0))
              run_cmd({4'b0110, s[2:0], r[0]}, h[0], w[0]);
          end
    // explicit read after set-reversible
    run_cmd(8'h62, 1'b1, 1'b0);
    run_cmd(8'h63, 1'b1, 1'b0);
    run_cmd(8'h67, 1'b1, 1'b0);
    run_cmd(8'h66, 1'b1, 1'b0);
    chk(lower_prot == 1'b0, "R4 clear reversible", lower_prot, 0);

    // R5: stop before data byte
    hv_a0 = 1'b1;
    bstart(); bbyte(8'h62); bbyte(8'h00); bstop();
    chk(lower_prot == 1'b0, "R5 truncated", lower_prot, 0);
    // R5: new start before stop
    bstart(); bbyte(8'h62); bbyte(8'h00); bbyte(8'h00); bstart(); bstop();
    chk(lower_prot == 1'b0, "R5 restart", lower_prot, 0);
    // R5: overlong
    bstart(); bbyte(8'h62); bbyte(8'h00); bbyte(8'h00); bbyte(8'h11);
    chk(ack_en == 1'b0, "R5 extra byte ack", ack_en, 0);
    bstop();
    chk(lower_prot == 1'b0, "R5 overlong", lower_prot, 0);
    // R6: wp rises before stop
    bstart(); bbyte(8'h62); bbyte(8'h00); bbyte(8'h00); wp = 1'b1; bstop(); wp = 1'b0;
    chk(lower_prot == 1'b0, "R6 wp at stop", lower_prot, 0);

    sweep_wr();

    // R4: set reversible, survives interface reset
    run_cmd(8'h62, 1'b1, 1'b0);
    pulse_rst();
    chk(lower_prot == 1'b1, "R4 reversible kept over rst_n", lower_prot, 1);
    sweep_wr();
    run_cmd(8'h66, 1'b1, 1'b0);

    // R9: permanent set
    run_cmd({4'b0110, STRAP, 1'b0}, 1'b0, 1'b0);
    chk(lower_prot == 1'b1, "R4 R9 permanent set", lower_prot, 1);
    run_cmd(8'h66, 1'b1, 1'b0);
    run_cmd(8'h62, 1'b1, 1'b0);
    run_cmd({4'b0110, STRAP, 1'b1}, 1'b0, 1'b0);
    wp = 1'b1; @(negedge clk); wp = 1'b0; @(negedge clk);
    chk(lower_prot == 1'b1, "R9 wp toggle", lower_prot, 1);
    pulse_rst();
    chk(lower_prot == 1'b1, "R9 rst_n", lower_prot, 1);
    hv_a0 = 1'b1;
    bstart(); bbyte(8'h66);
    chk(ack_en == 1'b0, "R9 clear after permanent", ack_en, 0);
    bbyte(8'h00); bbyte(8'h00); bstop();
    chk(lower_prot == 1'b1, "R9 still protected", lower_prot, 1);
    sweep_wr();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule